// File: doc/BRIEF.md
# Whole Vector Register Group Copier

This block executes the vector whole-register move: one 32-bit instruction word copies a group of 1, 2, 4 or 8 consecutive vector registers onto another group. It holds its own 32-entry vector register file, each entry VLEN bits wide. The copy always moves full registers as raw bytes. It does not look at any vector length, element type or mask setting, and no such setting enters the block. A host port reads and writes single registers when the block is idle, which is how contents are loaded and inspected.

An instruction is offered on `insn_valid` and taken while `insn_ready` is high. A controller with four states works through it. From IDLE it goes to COPY when an accepted word is legal, or to REJECT when the word is not legal. COPY writes one register per clock, lowest index first, and moves to FINISH after the last register of the group. FINISH pulses `done`, sets the sticky `vs_dirty` flag and returns to IDLE. REJECT pulses `done` and `illegal` together and returns to IDLE.

An aligned source group and an aligned destination group of the same size are either the same group or do not overlap. For that reason the copy needs no overlap ordering, and a copy of a group onto itself ends normally.

Top module: `vreg_group_mover`

## Requirements
- R1: A word is recognised only when bits [6:0]=1010111, bits [14:12]=011, bits [31:26]=100111 and bit 25=1. The field in bits [19:15] must be 00000, 00001, 00011 or 00111, which give a group of 1, 2, 4 or 8 registers. Every other word is rejected.
- R2: The destination index in bits [11:7] and the source index in bits [24:20] must each be a multiple of the group size. If either is not, the word is rejected and no register changes.
- R3: A word accepted while `vec_on` is 0 is rejected and no register changes.
- R4: A legal word copies source register s+k, with all VLEN bits, into destination register d+k for every k below the group size. All other registers keep their contents.
- R5: A legal word holds `busy` high for exactly as many cycles as the group size, starting the cycle after acceptance, and writes one register per cycle in ascending order.
- R6: `done` is high for exactly one cycle. After a legal word it follows the last busy cycle. After a rejected word it comes in the cycle after acceptance, together with `illegal`, and `busy` stays low.
- R7: `insn_ready` is high only in IDLE, so it is low during busy, done and illegal cycles.
- R8: `vs_dirty` is 0 after reset. It becomes 1 after the first legal copy and stays 1 until reset. Rejected words never set it.
- R9: A legal word whose source equals its destination completes with normal timing and leaves every register unchanged.
- R10: After reset the state is IDLE: `insn_ready`=1 and `busy`, `done`, `illegal` and `vs_dirty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_on | input | 1 | Vector unit enabled |
| insn_valid | input | 1 | Instruction word offered |
| insn | input | 32 | Instruction word |
| insn_ready | output | 1 | Block idle, word taken this cycle |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Word rejected (with done) |
| vs_dirty | output | 1 | Sticky vector-state-modified flag |
| host_we | input | 1 | Host register write (idle only) |
| host_waddr | input | 5 | Host write index |
| host_wdata | input | VLEN | Host write data |
| host_raddr | input | 5 | Host read index |
| host_rdata | output | VLEN | Host read data (combinational) |

## Verification
If a group counter or a base index is held wrong, the damage lands on the wrong register or in the wrong order. The bench finds it through the host read port as soon as the move ends, because it compares all 32 registers against its own model after every move. If the controller takes a wrong state transition, the number of busy cycles changes or the done/illegal pulse comes early, late or not at all. Each of these is seen within a few cycles of acceptance. Faulty decode or alignment logic makes a legal word come back illegal, or lets a rejected word change the register file. The bench checks both through the port flags and through the register contents.

// File: rtl/vreg_mover_pkg.sv
package vreg_mover_pkg;

    localparam int NREG    = 32;
    localparam int IDX_W   = 5;
    localparam int MAXGRP  = 8;
    localparam int SPAN_W  = $clog2(MAXGRP);

    localparam logic [6:0] OPC_VEC   = 7'b1010111;
    localparam logic [2:0] F3_IVI    = 3'b011;
    localparam logic [5:0] F6_WHOLE  = 6'b100111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_FINISH,
        ST_REJECT
    } mover_state_t;

    typedef struct packed {
        logic                   recognised;
        logic                   aligned;
        logic [SPAN_W-1:0]      span_m1;
        logic [IDX_W-1:0]       dst;
        logic [IDX_W-1:0]       src;
    } mover_dec_t;

endpackage

// File: rtl/vreg_mover_decode.sv
module vreg_mover_decode
    import vreg_mover_pkg::*;
(
    input  logic [31:0] word,
    output mover_dec_t  dec
);
    logic [4:0]        sel;
    logic [SPAN_W-1:0] low;
    logic              sel_ok;

    always_comb begin
        sel = word[19:15];
        low = sel[SPAN_W-1:0];
        // a valid group mask is a run of ones from bit 0: m & (m+1) == 0
        sel_ok = (sel[4:SPAN_W] == '0) && ((low & (low + 1'b1)) == '0);

        dec.recognised = (word[6:0] == OPC_VEC) && (word[14:12] == F3_IVI)
                       && (word[31:26] == F6_WHOLE) && word[25] && sel_ok;
        dec.span_m1    = low;
        dec.dst        = word[11:7];
        dec.src        = word[24:20];
        dec.aligned    = ((word[7 +: SPAN_W] & low) == '0)
                       && ((word[20 +: SPAN_W] & low) == '0);
    end
endmodule

// File: rtl/vreg_mover_regfile.sv
module vreg_mover_regfile
    import vreg_mover_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [VLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [VLEN-1:0]  rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [VLEN-1:0]  rdata_b
);
    logic [VLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/vreg_mover_ctrl.sv
module vreg_mover_ctrl
    import vreg_mover_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_on,
    input  logic             insn_valid,
    input  mover_dec_t       dec,
    output logic             insn_ready,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             vs_dirty,
    output logic             mv_we,
    output logic [IDX_W-1:0] mv_dst,
    output logic [IDX_W-1:0] mv_src
);
    mover_state_t      state, nxt;
    logic [SPAN_W-1:0] cnt, span_q;
    logic [IDX_W-1:0]  dst_q, src_q;
    logic              take, legal;

    assign take  = insn_valid && (state == ST_IDLE);
    assign legal = dec.recognised && dec.aligned && vec_on;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (take) nxt = legal ? ST_COPY : ST_REJECT;
            ST_COPY:   if (cnt == span_q) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // group bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            span_q <= '0;
            dst_q  <= '0;
            src_q  <= '0;
        end else if (take && legal) begin
            cnt    <= '0;
            span_q <= dec.span_m1;
            dst_q  <= dec.dst;
            src_q  <= dec.src;
        end else if (state == ST_COPY) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  vs_dirty <= 1'b0;
        else if (state == ST_FINISH) vs_dirty <= 1'b1;
    end

    // outputs
    always_comb begin
        insn_ready = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        illegal    = 1'b0;
        mv_we      = 1'b0;
        unique case (state)
            ST_IDLE:   insn_ready = 1'b1;
            ST_COPY:   begin busy = 1'b1; mv_we = 1'b1; end
            ST_FINISH: done = 1'b1;
            ST_REJECT: begin done = 1'b1; illegal = 1'b1; end
            default:   insn_ready = 1'b0;
        endcase
        mv_dst = dst_q + IDX_W'(cnt);
        mv_src = src_q + IDX_W'(cnt);
    end

    a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !insn_ready);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !busy));
    a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mv_dst == $past(mv_dst) + 1'b1));
    a_r5_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r8_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        vs_dirty |=> vs_dirty);
endmodule

// File: rtl/vreg_group_mover.sv
module vreg_group_mover
    import vreg_mover_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_on,
    input  logic             insn_valid,
    input  logic [31:0]      insn,
    output logic             insn_ready,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             vs_dirty,
    input  logic             host_we,
    input  logic [4:0]       host_waddr,
    input  logic [VLEN-1:0]  host_wdata,
    input  logic [4:0]       host_raddr,
    output logic [VLEN-1:0]  host_rdata
);
    mover_dec_t       dec;
    logic             mv_we;
    logic [IDX_W-1:0] mv_dst, mv_src, waddr;
    logic [VLEN-1:0]  mv_data, wdata;
    logic             we;

    vreg_mover_decode u_dec (.word(insn), .dec(dec));

    vreg_mover_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .vec_on(vec_on), .insn_valid(insn_valid),
        .dec(dec), .insn_ready(insn_ready), .busy(busy), .done(done),
        .illegal(illegal), .vs_dirty(vs_dirty), .mv_we(mv_we),
        .mv_dst(mv_dst), .mv_src(mv_src)
    );

    // mover owns the write port while copying
    assign we    = mv_we | host_we;
    assign waddr = mv_we ? mv_dst  : host_waddr;
    assign wdata = mv_we ? mv_data : host_wdata;

    vreg_mover_regfile #(.VLEN(VLEN)) u_rf (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(mv_src), .rdata_a(mv_data),
        .raddr_b(host_raddr), .rdata_b(host_rdata)
    );

    a_r4_copy_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mv_we |-> busy);
    a_r2_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mv_we);
endmodule

// File: tb/vreg_group_mover_test.sv
module vreg_group_mover_test;
    localparam int VLEN = 128;
    localparam int NW   = VLEN / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vec_on = 1'b1;
    logic insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic insn_ready, busy, done, illegal, vs_dirty;
    logic host_we = 1'b0;
    logic [4:0] host_waddr = '0, host_raddr = '0;
    logic [VLEN-1:0] host_wdata = '0;
    logic [VLEN-1:0] host_rdata;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [VLEN-1:0] model [32];

    always #5 clk = ~clk;

    vreg_group_mover #(.VLEN(VLEN)) uut (
        .clk(clk), .rst_n(rst_n), .vec_on(vec_on), .insn_valid(insn_valid),
        .insn(insn), .insn_ready(insn_ready), .busy(busy), .done(done),
        .illegal(illegal), .vs_dirty(vs_dirty), .host_we(host_we),
        .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 190000) begin
            mismatched = mismatched + 1;
            compared = compared + 1;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] f6, input logic vm,
            input logic [4:0] s2, input logic [4:0] s1, input logic [2:0] f3,
            input logic [4:0] d, input logic [6:0] opc);
        return {f6, vm, s2, s1, f3, d, opc};
    endfunction

    function automatic logic [VLEN-1:0] pat(input int r, input int seed);
        logic [VLEN-1:0] v;
        for (int w = 0; w < NW; w++)
            v[w*32 +: 32] = 32'(r) * 32'h01010101 + 32'(w) * 32'h00010001
                          + 32'(seed) * 32'h9E3779B1;
        return v;
    endfunction

    task automatic refill(input int seed);
        for (int r = 0; r < 32; r++) begin
            host_we = 1'b1;
            host_waddr = 5'(r);
            host_wdata = pat(r, seed);
            model[r] = pat(r, seed);
            @(negedge clk);
        end
        host_we = 1'b0;
    endtask

    task automatic compare_all(input string req);
        for (int r = 0; r < 32; r++) begin
            host_raddr = 5'(r);
            #1;
            check(host_rdata === model[r], req, host_rdata, model[r]);
        end
    endtask

    // exp_n = group size for a legal word, 0 for a rejected one
    task automatic run_word(input logic [31:0] w, input bit on, input int exp_n,
                            input string req);
        int nbusy = 0;
        int guard = 0;
        check(insn_ready === 1'b1, "R7 ready before issue", VLEN'(insn_ready), 1);
        vec_on = on;
        insn = w;
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        while (done !== 1'b1 && guard < 20) begin
            if (busy === 1'b1) begin
                nbusy++;
                check(insn_ready === 1'b0, "R7 ready low while busy", VLEN'(insn_ready), 0);
            end
            @(negedge clk);
            guard++;
        end
        check(nbusy == exp_n, {req, " R5 busy cycles"}, VLEN'(nbusy), VLEN'(exp_n));
        check(done === 1'b1, {req, " R6 done seen"}, VLEN'(done), 1);
        check(illegal === (exp_n == 0), {req, " R6 illegal flag"}, VLEN'(illegal),
              VLEN'(exp_n == 0));
        check(busy === 1'b0 && insn_ready === 1'b0, {req, " R7 done cycle"},
              VLEN'({busy, insn_ready}), 0);
        @(negedge clk);
        check(done === 1'b0 && illegal === 1'b0 && insn_ready === 1'b1,
              {req, " R6 single pulse"}, VLEN'({done, illegal, insn_ready}), VLEN'(1));
        vec_on = 1'b1;
    endtask

    initial begin
        int seed = 1;
        int sizes[4] = '{1, 2, 4, 8};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check({insn_ready, busy, done, illegal, vs_dirty} === 5'b10000, "R10 reset",
              VLEN'({insn_ready, busy, done, illegal, vs_dirty}), VLEN'(5'b10000));

        refill(seed);
        // R1 rejected encodings
        run_word(enc(6'b100111, 1'b1, 5'd0, 5'b00010, 3'b011, 5'd0, 7'b1010111), 1, 0, "R1 rs1=2");
        run_word(enc(6'b100111, 1'b1, 5'd0, 5'b01111, 3'b011, 5'd0, 7'b1010111), 1, 0, "R1 rs1=15");
        run_word(enc(6'b100111, 1'b1, 5'd0, 5'b00100, 3'b011, 5'd0, 7'b1010111), 1, 0, "R1 rs1=4");
        run_word(enc(6'b100111, 1'b0, 5'd0, 5'b00000, 3'b011, 5'd8, 7'b1010111), 1, 0, "R1 vm=0");
        run_word(enc(6'b100111, 1'b1, 5'd0, 5'b00000, 3'b010, 5'd8, 7'b1010111), 1, 0, "R1 funct3");
        run_word(enc(6'b100110, 1'b1, 5'd0, 5'b00000, 3'b011, 5'd8, 7'b1010111), 1, 0, "R1 funct6");
        run_word(enc(6'b100111, 1'b1, 5'd0, 5'b00000, 3'b011, 5'd8, 7'b1010011), 1, 0, "R1 opcode");
        // R3 vector unit off
        run_word(enc(6'b100111, 1'b1, 5'd4, 5'b00011, 3'b011, 5'd8, 7'b1010111), 0, 0, "R3 vec off");
        compare_all("R3 R1 nothing written");
        // R2 misaligned groups
        for (int si = 1; si < 4; si++) begin
            for (int x = 0; x < 32; x++) begin
                if (x % sizes[si] != 0) begin
                    run_word(enc(6'b100111, 1'b1, 5'd0, 5'(sizes[si]-1), 3'b011, 5'(x), 7'b1010111),
                             1, 0, "R2 dst misaligned");
                    run_word(enc(6'b100111, 1'b1, 5'(x), 5'(sizes[si]-1), 3'b011, 5'd0, 7'b1010111),
                             1, 0, "R2 src misaligned");
                end
            end
        end
        compare_all("R2 nothing written");
        check(vs_dirty === 1'b0, "R8 no dirty after rejects", VLEN'(vs_dirty), 0);

        // R4 R5 R9 exhaustive aligned sweep
        for (int si = 0; si < 4; si++) begin
            int n = sizes[si];
            for (int d = 0; d < 32; d += n) begin
                for (int s = 0; s < 32; s += n) begin
                    logic [VLEN-1:0] tmp [8];
                    seed++;
                    refill(seed);
                    run_word(enc(6'b100111, 1'b1, 5'(s), 5'(n-1), 3'b011, 5'(d), 7'b1010111),
                             1, n, (d == s) ? "R9 self move" : "R4 move");
                    for (int k = 0; k < n; k++) tmp[k] = model[s+k];
                    for (int k = 0; k < n; k++) model[d+k] = tmp[k];
                    compare_all((d == s) ? "R9 contents" : "R4 contents");
                    check(vs_dirty === 1'b1, "R8 dirty after move", VLEN'(vs_dirty), 1);
                end
            end
        end

        // R8 rejected word leaves dirty set
        run_word(enc(6'b100111, 1'b1, 5'd1, 5'b00001, 3'b011, 5'd0, 7'b1010111), 1, 0, "R2 late reject");
        check(vs_dirty === 1'b1, "R8 dirty sticky", VLEN'(vs_dirty), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule